// File: doc/BRIEF.md
# Wake-up Input Debounce Aggregator

This block watches a set of asynchronous wake-up pins from the always-on slow-clock domain. Each pin has its own enable and its own active level. A single shared code selects how long a pin has to stay at its active level before it counts as a wake event. When an enabled pin completes that hold time, the block pulses a wake request for the core supply. It also sets a sticky wake flag and records which enabled pins were at their active level at that moment.

A status-read strobe clears the sticky flag and the snapshot. Each pin goes through a two-flop synchronizer. Before a pin can start a hold it has to be seen at its inactive level, so only a transition into the active level followed by a steady level produces a wake. After a wake, the pin must go back to its inactive level before it can produce another one. Decoding of the configuration register, pad behaviour and power switching are handled outside this block.

Top module: `wkup_debounce_agg`

## Requirements
- R1: After reset, `wake_req_o`, `wake_flag_o` and `wake_snap_o` are all 0.
- R2: Pin i is active when its synchronized level equals `wk_pol_i[i]` (1 = active high, 0 = active low). A wake requires a transition into the active level followed by the hold time, so a pin that is already active when it gets armed at reset does not wake.
- R3: With code 0 (immediate), one active sample is enough. If a pin changes between two clock edges, the outputs change at the 3rd rising edge after the change.
- R4: Codes 1, 2, 3, 4 and 5 need 3, 32, 512, 4096 and 32768 consecutive active slow-clock periods. The outputs change at the (N+2)th rising edge after the pin change. A pin that leaves its active level before the count completes restarts its count from zero.
- R5: Codes 6 and 7 behave exactly like code 0.
- R6: A pin whose enable bit is 0 never causes a wake request, flag or snapshot bit, whatever its level.
- R7: `wake_flag_o` sets on any wake and stays set until `stat_rd_i` is sampled high. It then reads 0 from the next edge on, and `wake_snap_o` is cleared with it.
- R8: On a wake, bit i of `wake_snap_o` is set for every pin that is enabled and at its active level in that cycle. Disabled or inactive pins leave their bit at 0. Set bits stay set until a read.
- R9: If a read and a wake fall on the same edge, the flag stays set. The snapshot then holds only the pins captured by the new wake.
- R10: A pin held active after its wake does not wake again. It must go back to its inactive level first.
- R11: `wake_req_o` is high for exactly one cycle per wake, on the same edge where the flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wk_pin_i | input | NUM_IN | Asynchronous wake-up pins |
| wk_en_i | input | NUM_IN | Per-pin enable |
| wk_pol_i | input | NUM_IN | Per-pin active level |
| dbc_code_i | input | 3 | Shared debounce length code |
| stat_rd_i | input | 1 | Status read strobe, clears flag and snapshot |
| wake_req_o | output | 1 | One-cycle wake request |
| wake_flag_o | output | 1 | Sticky wake flag |
| wake_snap_o | output | NUM_IN | Pins active and enabled at the last wake |

## Verification
The hardest cases to reach are the longest hold (32768 periods), checked exactly at its boundary, and a read strobe that lands on the very edge where a wake registers. The stimulus drives pins at falling edges and counts rising edges. This places each expected change at edge N+2 and the read strobe at the trigger edge. A broken pulse train with four active samples but never three in a row exercises the count restart. The bench also flips a pin's polarity while that pin is disabled, so the pin is armed at the new inactive level before it is enabled.

// File: rtl/wkup_pkg.sv
`timescale 1ns/1ps
package wkup_pkg;

    localparam int unsigned DBC_CODE_W = 3;

    // shared debounce length selector; 6 and 7 are reserved
    typedef enum logic [DBC_CODE_W-1:0] {
        DB_IMM  = 3'd0,
        DB_L1   = 3'd1,
        DB_L2   = 3'd2,
        DB_L3   = 3'd3,
        DB_L4   = 3'd4,
        DB_L5   = 3'd5,
        DB_RSV6 = 3'd6,
        DB_RSV7 = 3'd7
    } dbc_code_e;

endpackage

// File: rtl/wkup_sync.sv
`timescale 1ns/1ps
module wkup_sync #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = async_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_o = q.s2;

endmodule

// File: rtl/wkup_len_dec.sv
`timescale 1ns/1ps
module wkup_len_dec
    import wkup_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LEN1  = 3,
    parameter int unsigned LEN2  = 32,
    parameter int unsigned LEN3  = 512,
    parameter int unsigned LEN4  = 4096,
    parameter int unsigned LEN5  = 32768
) (
    input  logic [DBC_CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]      lim_o
);

    // lim_o is the hold length minus one: the count value at which
    // the final active sample is seen
    always_comb begin
        case (dbc_code_e'(code_i))
            DB_L1:   lim_o = CNT_W'(LEN1 - 1);
            DB_L2:   lim_o = CNT_W'(LEN2 - 1);
            DB_L3:   lim_o = CNT_W'(LEN3 - 1);
            DB_L4:   lim_o = CNT_W'(LEN4 - 1);
            DB_L5:   lim_o = CNT_W'(LEN5 - 1);
            default: lim_o = '0;
        endcase
    end

endmodule

// File: rtl/wkup_chan.sv
`timescale 1ns/1ps
module wkup_chan #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    input  logic             pol_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             trig_o,
    output logic             act_o
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } chan_t;

    chan_t d, q;
    logic  active;

    assign active = (lvl_i == pol_i);
    assign act_o  = en_i & active;
    assign trig_o = en_i & q.armed & active & (q.cnt >= lim_i);

    always_comb begin
        d = q;
        // arming tracks the level even while disabled
        if (!active)     d.armed = 1'b1;
        else if (trig_o) d.armed = 1'b0;

        if (!en_i || !active || !q.armed || trig_o) d.cnt = '0;
        else                                        d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R4
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (q.cnt == '0));

    // R6
    dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q.cnt == '0));

endmodule

// File: rtl/wkup_status.sv
`timescale 1ns/1ps
module wkup_status #(
    parameter int unsigned N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig_i,
    input  logic [N-1:0] act_i,
    input  logic         rd_i,
    output logic         req_o,
    output logic         flag_o,
    output logic [N-1:0] snap_o
);

    typedef struct packed {
        logic         req;
        logic         flag;
        logic [N-1:0] snap;
    } stat_t;

    stat_t d, q;
    logic  any_trig;

    assign any_trig = |trig_i;

    always_comb begin
        d      = q;
        d.req  = any_trig;
        // a new wake on the read edge takes precedence
        d.flag = any_trig | (q.flag & ~rd_i);
        d.snap = (rd_i ? '0 : q.snap) | (any_trig ? act_i : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_o  = q.req;
    assign flag_o = q.flag;
    assign snap_o = q.snap;

    // R7 R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_trig |=> q.flag);

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !any_trig) |=> (!q.flag && q.snap == '0));

    // R8
    snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((q.snap & $past(q.snap)) == $past(q.snap)));

endmodule

// File: rtl/wkup_debounce_agg.sv
`timescale 1ns/1ps
module wkup_debounce_agg
    import wkup_pkg::*;
#(
    parameter int unsigned NUM_IN = 14,
    parameter int unsigned LEN1   = 3,
    parameter int unsigned LEN2   = 32,
    parameter int unsigned LEN3   = 512,
    parameter int unsigned LEN4   = 4096,
    parameter int unsigned LEN5   = 32768
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IN-1:0]     wk_pin_i,
    input  logic [NUM_IN-1:0]     wk_en_i,
    input  logic [NUM_IN-1:0]     wk_pol_i,
    input  logic [DBC_CODE_W-1:0] dbc_code_i,
    input  logic                  stat_rd_i,
    output logic                  wake_req_o,
    output logic                  wake_flag_o,
    output logic [NUM_IN-1:0]     wake_snap_o
);

    localparam int unsigned CNT_W = $clog2(LEN5 + 1);

    logic [NUM_IN-1:0] lvl_sync;
    logic [NUM_IN-1:0] trig_vec;
    logic [NUM_IN-1:0] act_vec;
    logic [CNT_W-1:0]  lim;

    wkup_sync #(.W(NUM_IN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (wk_pin_i),
        .sync_o  (lvl_sync)
    );

    wkup_len_dec #(
        .CNT_W (CNT_W),
        .LEN1  (LEN1),
        .LEN2  (LEN2),
        .LEN3  (LEN3),
        .LEN4  (LEN4),
        .LEN5  (LEN5)
    ) u_len (
        .code_i (dbc_code_i),
        .lim_o  (lim)
    );

    for (genvar i = 0; i < NUM_IN; i++) begin : g_chan
        wkup_chan #(.CNT_W(CNT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl_sync[i]),
            .pol_i  (wk_pol_i[i]),
            .en_i   (wk_en_i[i]),
            .lim_i  (lim),
            .trig_o (trig_vec[i]),
            .act_o  (act_vec[i])
        );
    end

    wkup_status #(.N(NUM_IN)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_vec),
        .act_i  (act_vec),
        .rd_i   (stat_rd_i),
        .req_o  (wake_req_o),
        .flag_o (wake_flag_o),
        .snap_o (wake_snap_o)
    );

    // R11
    req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> wake_flag_o);

    // R6
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_en_i == '0) |=> !wake_req_o);

endmodule

// File: tb/wkup_debounce_agg_tb.sv
`timescale 1ns/1ps
module wkup_debounce_agg_tb;

    localparam int NI = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] pin = '0;
    logic [NI-1:0] en = '0;
    logic [NI-1:0] pol = '1;
    logic [2:0]    code = 3'd0;
    logic          rd = 1'b0;
    logic          req;
    logic          flag;
    logic [NI-1:0] snap;

    int unsigned cyc = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;

    typedef struct {
        int unsigned   at;
        logic          flag;
        logic          req;
        logic [NI-1:0] snap;
        string         tag;
    } item_t;

    item_t exp_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    wkup_debounce_agg u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wk_pin_i    (pin),
        .wk_en_i     (en),
        .wk_pol_i    (pol),
        .dbc_code_i  (code),
        .stat_rd_i   (rd),
        .wake_req_o  (req),
        .wake_flag_o (flag),
        .wake_snap_o (snap)
    );

    task automatic push(input int unsigned at, input logic f, input logic r,
                        input logic [NI-1:0] s, input string tag);
        item_t it;
        it.at = at; it.flag = f; it.req = r; it.snap = s; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_clr(input string tag);
        rd = 1'b1;
        push(cyc + 1, 1'b0, 1'b0, '0, tag);
        step(1);
        rd = 1'b0;
    endtask

    // raise pin b to its active level and expect a wake after n periods
    task automatic run_len(input logic [2:0] c, input int n, input int b, input string tag);
        int unsigned c0;
        logic [NI-1:0] bit_m;
        bit_m = NI'(1) << b;
        code = c;
        en[b] = 1'b1;
        step(3);
        c0 = cyc;
        pin[b] = pol[b];
        push(c0 + n + 1, 1'b0, 1'b0, '0, {tag, " before hold end"});
        push(c0 + n + 2, 1'b1, 1'b1, bit_m, {tag, " wake edge"});
        push(c0 + n + 3, 1'b1, 1'b0, bit_m, {tag, " R11 single pulse"});
        step(n + 4);
        pin[b] = ~pol[b];
        step(3);
        read_clr({tag, " R7 read clears"});
        en[b] = 1'b0;
    endtask

    // monitor: compares each queued item at its cycle
    always @(negedge clk) begin
        item_t it;
        while (!done && exp_q.size() > 0 && exp_q[0].at <= cyc) begin
            it = exp_q.pop_front();
            checks++;
            if (it.at != cyc || flag !== it.flag || req !== it.req || snap !== it.snap) begin
                fails++;
                $display("FAIL %s @%0d: flag=%0b req=%0b snap=%h expected flag=%0b req=%0b snap=%h (cycle %0d)",
                         it.tag, cyc, flag, req, snap, it.flag, it.req, it.snap, it.at);
            end
        end
    end

    initial begin : driver
        int unsigned c0;
        step(3);
        rst_n = 1'b1;
        push(cyc + 1, 1'b0, 1'b0, '0, "R1 reset state");
        step(4);

        // R3 immediate on pin 0, then R10 held level
        en[0] = 1'b1; code = 3'd0;
        step(3);
        c0 = cyc;
        pin[0] = 1'b1;
        push(c0 + 2, 1'b0, 1'b0, '0, "R3 not before third edge");
        push(c0 + 3, 1'b1, 1'b1, 14'h0001, "R3 immediate wake");
        push(c0 + 4, 1'b1, 1'b0, 14'h0001, "R11 pulse ends");
        push(c0 + 20, 1'b1, 1'b0, 14'h0001, "R7 flag sticky");
        step(25);
        read_clr("R7 read clears");
        push(cyc + 10, 1'b0, 1'b0, '0, "R10 no second wake while held");
        step(12);
        pin[0] = 1'b0;
        step(3);
        c0 = cyc;
        pin[0] = 1'b1;
        push(c0 + 3, 1'b1, 1'b1, 14'h0001, "R10 wake after return to inactive");
        step(5);
        pin[0] = 1'b0;
        step(3);
        read_clr("R7 read clears again");
        en[0] = 1'b0;

        // R3, R4, R5 lengths
        run_len(3'd0, 1, 1, "R3 code0");
        run_len(3'd1, 3, 2, "R4 code1");
        run_len(3'd2, 32, 3, "R4 code2");
        run_len(3'd3, 512, 5, "R4 code3");
        run_len(3'd4, 4096, 6, "R4 code4");
        run_len(3'd5, 32768, 12, "R4 code5");
        run_len(3'd6, 1, 13, "R5 code6");
        run_len(3'd7, 1, 10, "R5 code7");

        // R2 active-low on pin 4: arm at high level while disabled
        pol[4] = 1'b0; pin[4] = 1'b1;
        step(3);
        run_len(3'd1, 3, 4, "R2 active low");

        // R4 broken pulse: 2 active, 1 inactive, 2 active
        code = 3'd1; en[2] = 1'b1;
        step(3);
        c0 = cyc;
        pin[2] = 1'b1; step(2);
        pin[2] = 1'b0; step(1);
        pin[2] = 1'b1; step(2);
        pin[2] = 1'b0;
        push(c0 + 12, 1'b0, 1'b0, '0, "R4 count restarts on drop");
        step(14);
        en[2] = 1'b0;

        // R6 disabled pin 7 high for a long time
        code = 3'd0;
        c0 = cyc;
        pin[7] = 1'b1;
        push(c0 + 10, 1'b0, 1'b0, '0, "R6 disabled pin ignored");
        step(12);

        // R8 snapshot: pin 8 enabled, pin 9 disabled, pin 0 enabled but low
        en[8] = 1'b1; en[0] = 1'b1;
        step(2);
        c0 = cyc;
        pin[8] = 1'b1; pin[9] = 1'b1;
        push(c0 + 3, 1'b1, 1'b1, 14'h0100, "R8 snapshot only enabled active");
        step(6);

        // R9 read on the same edge as a new wake from pin 11
        en[11] = 1'b1;
        step(2);
        c0 = cyc;
        pin[11] = 1'b1;
        push(c0 + 3, 1'b1, 1'b1, 14'h0900, "R9 wake wins over read");
        step(2);
        rd = 1'b1;
        step(1);
        rd = 1'b0;
        step(3);
        read_clr("R7 final clear");
        pin = '0; en = '0;
        step(5);

        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R1 queue: %0d items left expected 0", exp_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog R1: run=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule